// File: doc/BRIEF.md
# Successive-Approximation Switch Sequencer

This block is the digital sequencer for a successive-approximation converter that uses a binary-weighted capacitor array. When it gets a start strobe, it spends one clock sampling. During that clock the common top plate is held at ground and every bottom plate is tied to the analog input. It then runs one bit trial per clock, from the most significant bit down to the least. In each trial it places the bit under test on the reference, and the comparator reports the sign of the resulting residue.

The comparator polarity is inverted. A decision of "residue negative" (`cmpNeg` = 1) means the trial level did not exceed the input, so the bit is kept. A kept bit leaves its capacitor on the reference for the rest of the conversion. A rejected bit sends its capacitor back to ground before the next trial. After the last trial the sequencer loads the result register, pulses `donePulse` for one cycle and returns to idle.

Top module: `sar_switch_ctrl`

## Requirements
- R1: After reset, `busy` and `donePulse` are 0 and `result` is 0. The idle switch pattern is `topGnd`=1, `botSelIn`=0 and `botSelRef`=0.
- R2: A `startPulse` sampled in idle gives the sample pattern in the next cycle: `topGnd`=1, `botSelIn` all ones, `botSelRef`=0, with `busy`=1.
- R3: The cycle after sampling is the MSB trial. It drives `topGnd`=0, `botSelIn`=0 and `botSelRef` with only bit NBITS-1 set.
- R4: The trial on bit i sets `botSelRef` bit i to 1. Each higher bit shows its already decided value, and all lower bits are 0. A bit that is not on the reference is on ground.
- R5: `cmpNeg` is sampled on the clock edge that ends each trial. A 1 keeps the bit and a 0 clears it. With 6 bits and an input of exactly 5/8 of the reference (a residue of zero at the third trial counts as negative), the result is 101000.
- R6: `donePulse` rises exactly NBITS+1 cycles after the start edge, lasts one cycle, and appears together with the new `result`.
- R7: `result` changes only in the cycle in which `donePulse` is high.
- R8: A `startPulse` during a conversion has no effect on the switch sequence, the result or the done timing.
- R9: In the cycle after `donePulse`, the outputs show the idle pattern with `busy`=0, and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a conversion when idle |
| cmpNeg | input | 1 | Comparator decision, 1 = residue negative (keep bit) |
| topGnd | output | 1 | Top plate switched to ground |
| botSelIn | output | NBITS | Per-capacitor bottom plate to analog input |
| botSelRef | output | NBITS | Per-capacitor bottom plate to reference (0 = ground unless on input) |
| busy | output | 1 | Conversion in progress |
| donePulse | output | 1 | One-cycle end-of-conversion flag |
| result | output | NBITS | Last converted code |

## Verification
The bench models the array as a behavioural residue. It compares the reference-weighted code against an input held at a finer resolution, so some inputs land exactly on a trial level. The equality case, full scale and zero catch a sequencer that flips polarity or treats a zero residue as positive; such a design would return 100111 instead of 101000. Each trial's reference pattern is compared against one derived from the expected code. This catches a design that never returns a rejected capacitor to ground, which would leave stale bits set, and a design that drops kept bits. Starts injected in the middle of a conversion expose a design that restarts, which would show a second sample phase and a late done pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } sarState_e;

  typedef struct packed {
    logic loadSample;
    logic firstTrial;
    logic stepTrial;
    logic lastTrial;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int NBITS = 6,
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  output sar_pkg::sarStrobe_t strobe,
  output logic [IW-1:0]      bitIdx,
  output logic               busy
);
  import sar_pkg::*;

  sarState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (startPulse) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          state  <= ST_TRIAL;
          bitIdx <= IW'(NBITS - 1);
        end
        ST_TRIAL: begin
          if (bitIdx == '0) state <= ST_IDLE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadSample = (state == ST_IDLE) && startPulse;
    strobe.firstTrial = (state == ST_SAMPLE);
    strobe.stepTrial  = (state == ST_TRIAL);
    strobe.lastTrial  = (state == ST_TRIAL) && (bitIdx == '0);
    busy              = (state != ST_IDLE);
  end
endmodule

// File: rtl/sar_dp.sv
module sar_dp #(
  parameter int NBITS = 6,
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  sar_pkg::sarStrobe_t strobe,
  input  logic [IW-1:0]      bitIdx,
  input  logic               cmpNeg,
  output logic               topGnd,
  output logic [NBITS-1:0]   botSelIn,
  output logic [NBITS-1:0]   botSelRef,
  output logic               donePulse,
  output logic [NBITS-1:0]   result
);
  logic [NBITS-1:0] curMask;
  logic [NBITS-1:0] nextMask;
  logic [NBITS-1:0] keptBits;

  always_comb begin
    curMask  = NBITS'(1) << bitIdx;
    nextMask = curMask >> 1;
    keptBits = (botSelRef & ~curMask) | (cmpNeg ? curMask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topGnd    <= 1'b1;
      botSelIn  <= '0;
      botSelRef <= '0;
      donePulse <= 1'b0;
      result    <= '0;
    end else begin
      donePulse <= 1'b0;
      if (strobe.loadSample) begin
        topGnd    <= 1'b1;
        botSelIn  <= '1;
        botSelRef <= '0;
      end else if (strobe.firstTrial) begin
        topGnd    <= 1'b0;
        botSelIn  <= '0;
        botSelRef <= NBITS'(1) << (NBITS - 1);
      end else if (strobe.stepTrial) begin
        if (strobe.lastTrial) begin
          result    <= keptBits;
          donePulse <= 1'b1;
          topGnd    <= 1'b1;
          botSelRef <= '0;
        end else begin
          botSelRef <= keptBits | nextMask;
        end
      end
    end
  end
endmodule

// File: rtl/sar_switch_ctrl.sv
module sar_switch_ctrl #(
  parameter int NBITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             cmpNeg,
  output logic             topGnd,
  output logic [NBITS-1:0] botSelIn,
  output logic [NBITS-1:0] botSelRef,
  output logic             busy,
  output logic             donePulse,
  output logic [NBITS-1:0] result
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

  sar_pkg::sarStrobe_t strobe;
  logic [IW-1:0]       bitIdx;

  sar_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .strobe(strobe), .bitIdx(bitIdx), .busy(busy)
  );

  sar_dp #(.NBITS(NBITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .cmpNeg(cmpNeg), .topGnd(topGnd), .botSelIn(botSelIn),
    .botSelRef(botSelRef), .donePulse(donePulse), .result(result)
  );
endmodule

// File: rtl/sar_switch_chk.sv
module sar_switch_chk #(
  parameter int NBITS = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             cmpNeg,
  input logic             topGnd,
  input logic [NBITS-1:0] botSelIn,
  input logic [NBITS-1:0] botSelRef,
  input logic             busy,
  input logic             donePulse,
  input logic [NBITS-1:0] result
);
  // R4: a bottom plate is never on input and reference at once
  a_r4_no_double_select: assert property (@(posedge clk) disable iff (!rstN)
    (botSelIn & botSelRef) == '0);

  // R3: input switches are only closed while the top plate is grounded
  a_r3_input_needs_gnd: assert property (@(posedge clk) disable iff (!rstN)
    !topGnd |-> botSelIn == '0);

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7: result only moves together with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |=> (donePulse || $stable(result)));

  // R8: a start while busy never reopens the sample phase
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !donePulse && startPulse && !topGnd && botSelRef[0] == 1'b0) |=> botSelIn == '0);

  // R9: idle pattern right after done
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && topGnd && botSelIn == '0 && botSelRef == '0));
endmodule

bind sar_switch_ctrl sar_switch_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sar_switch_ctrl_tb.sv
module sar_switch_ctrl_tb;
  localparam int NBITS = 6;
  localparam int CLK_PERIOD = 10;
  localparam int FINE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic cmpNeg;
  logic topGnd, busy, donePulse;
  logic [NBITS-1:0] botSelIn, botSelRef, result;
  int vinFine = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural array + comparator: residue = DAC level - input, zero counts negative
  always_comb cmpNeg = (int'(botSelRef) * FINE) <= vinFine;

  sar_switch_ctrl #(.NBITS(NBITS)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpNeg(cmpNeg),
    .topGnd(topGnd), .botSelIn(botSelIn), .botSelRef(botSelRef),
    .busy(busy), .donePulse(donePulse), .result(result)
  );

  function automatic int expCode(int v);
    int c = v / FINE;
    if (c > (1 << NBITS) - 1) c = (1 << NBITS) - 1;
    return c;
  endfunction

  function automatic int expRef(int code, int i);
    return ((code >> (i + 1)) << (i + 1)) | (1 << i);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start edge, then sample at each negedge
  task automatic runConv(int vin, bit inject);
    int code = expCode(vin);
    int prevResult = int'(result);
    vinFine = vin;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = inject;
    check("R2 topGnd", int'(topGnd), 1);
    check("R2 botSelIn", int'(botSelIn), (1 << NBITS) - 1);
    check("R2 botSelRef", int'(botSelRef), 0);
    check("R2 busy", int'(busy), 1);
    for (int i = NBITS - 1; i >= 0; i--) begin
      @(negedge clk);
      if (i == NBITS - 1) begin
        check("R3 topGnd", int'(topGnd), 0);
        check("R3 MSB ref", int'(botSelRef), expRef(code, i));
      end else begin
        check(inject ? "R8 trial ref" : "R4 trial ref", int'(botSelRef), expRef(code, i));
      end
      check("R4 botSelIn", int'(botSelIn), 0);
      check("R7 result held", int'(result), prevResult);
      check("R6 no early done", int'(donePulse), 0);
    end
    startPulse = 1'b0;
    @(negedge clk);
    check("R6 done", int'(donePulse), 1);
    check("R5 result", int'(result), code);
    @(negedge clk);
    check("R6 done drops", int'(donePulse), 0);
    check("R9 idle", {busy, topGnd, botSelIn, botSelRef} == {2'b01, {(2*NBITS){1'b0}}} ? 1 : 0, 1);
    check("R7 result kept", int'(result), code);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(donePulse), 0);
    check("R1 result", int'(result), 0);
    check("R1 topGnd", int'(topGnd), 1);
    check("R1 switches", int'(botSelIn | botSelRef), 0);
    rstN = 1'b1;
    @(negedge clk);
    runConv(5 * NBITS'(0) + (5 << NBITS) * FINE / 8, 1'b0);  // R5: exactly 5/8 full scale
    runConv(0, 1'b0);
    runConv((1 << NBITS) * FINE - 1, 1'b0);
    runConv((1 << (NBITS - 1)) * FINE - 1, 1'b1);  // R8 just below half
    runConv((1 << (NBITS - 1)) * FINE, 1'b0);
    for (int n = 0; n < 40; n++) begin
      runConv(int'($urandom_range((1 << NBITS) * FINE - 1)), n % 3 == 0);
      if (n % 4 == 1) @(negedge clk);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule